// File: doc/BRIEF.md
# UART Grouped Interrupt Controller

This block gathers the interrupt events of a serial port into one sticky status word of eleven bits. It masks that word with an enable register and drives six level interrupt lines from the result. Five of the lines each serve one class of events: receive data, transmit space, receive timeout, line errors and modem-status changes. The sixth line is the OR of all of them, so a system can wire either the single summary line or the individual lines to its interrupt controller.

Event sources in the FIFOs, the serializer and the modem-control logic pulse one-cycle set strobes. A status bit stays set until software clears it by writing a one to that bit position through the clear port. Software reads the raw and the masked status words through the bus logic, which is outside this block. That bus logic writes the enable register and the clear register through simple write-enable and data ports.

Top module: `uart_irq_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the raw status, the masked status and all six interrupt lines are zero, and the enable register holds zero.
- R2: A set strobe makes its status bit 1 at the next clock edge, and the bit then stays 1 until cleared. The strobes map as follows: `ev_err[3:0]` (overrun, break, parity, framing) to bits 10..7, `ev_rxto` to bit 6, `ev_tx` to bit 5, `ev_rx` to bit 4, and `ev_modem[3:0]` (DSR, DCD, CTS, ring) to bits 3..0.
- R3: `masked_stat` always equals `raw_stat` bitwise ANDed with the enable register.
- R4: A cycle with `enable_we` high loads `enable_wdata` into the enable register at the next clock edge, replacing every bit.
- R5: A cycle with `clear_we` high clears, at the next edge, every raw bit whose `clear_wdata` bit is 1. Bits written as 0 keep their value, so a clear write of all zeros changes nothing.
- R6: When a set strobe and a clear of the same bit arrive in the same cycle, the bit ends up 1.
- R7: `irq_rx`, `irq_tx` and `irq_rxto` equal masked status bits 4, 5 and 6 respectively.
- R8: `irq_err` is the OR of masked bits 10..7, and `irq_modem` is the OR of masked bits 3..0.
- R9: `irq_any` is the OR of all eleven masked bits.
- R10: All six lines are registered. They change at the same clock edge as the raw status or enable register that drives them, which is one clock after the strobe or write, and never earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_rx | input | 1 | Receive-data event strobe |
| ev_tx | input | 1 | Transmit-space event strobe |
| ev_rxto | input | 1 | Receive-timeout event strobe |
| ev_err | input | 4 | Error strobes: overrun, break, parity, framing (MSB first) |
| ev_modem | input | 4 | Modem strobes: DSR, DCD, CTS, ring (MSB first) |
| enable_we | input | 1 | Enable register write strobe |
| enable_wdata | input | 11 | Enable register write data |
| clear_we | input | 1 | Clear register write strobe |
| clear_wdata | input | 11 | Bits to clear (write one to clear) |
| raw_stat | output | 11 | Raw sticky status |
| masked_stat | output | 11 | Raw status ANDed with enables |
| irq_any | output | 1 | Combined interrupt line |
| irq_rx | output | 1 | Receive line |
| irq_tx | output | 1 | Transmit line |
| irq_rxto | output | 1 | Receive-timeout line |
| irq_modem | output | 1 | Modem-status line |
| irq_err | output | 1 | Error line |

## Verification
A stuck or wrongly routed status bit shows on `raw_stat` at the edge after its strobe. A lost enable bit shows on `masked_stat` at the edge after its write. A line register that disagrees with the masked word is visible in the same cycle as a mismatch between a line and the OR of its group. A set-versus-clear priority error shows as a bit that reads 0 one cycle after a coincident set and clear. In each case the fault reaches the ports within one clock, so checks sampled at the falling edge after each stimulus catch it.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int unsigned STAT_W    = 11;
    localparam int unsigned NUM_LINES = 6;

    // status bit positions (software decodes these)
    localparam int unsigned B_OVR   = 10;
    localparam int unsigned B_BRK   = 9;
    localparam int unsigned B_PAR   = 8;
    localparam int unsigned B_FRM   = 7;
    localparam int unsigned B_RXTO  = 6;
    localparam int unsigned B_TX    = 5;
    localparam int unsigned B_RX    = 4;
    localparam int unsigned B_DSR   = 3;
    localparam int unsigned B_DCD   = 2;
    localparam int unsigned B_CTS   = 1;
    localparam int unsigned B_RING  = 0;

    typedef logic [STAT_W-1:0] stat_t;

    localparam stat_t GRP_ERR   = stat_t'((1 << B_OVR) | (1 << B_BRK) | (1 << B_PAR) | (1 << B_FRM));
    localparam stat_t GRP_MODEM = stat_t'((1 << B_DSR) | (1 << B_DCD) | (1 << B_CTS) | (1 << B_RING));
    localparam stat_t GRP_RX    = stat_t'(1 << B_RX);
    localparam stat_t GRP_TX    = stat_t'(1 << B_TX);
    localparam stat_t GRP_RXTO  = stat_t'(1 << B_RXTO);
    localparam stat_t GRP_ALL   = GRP_ERR | GRP_MODEM | GRP_RX | GRP_TX | GRP_RXTO;

    // line index order
    localparam int unsigned L_ANY   = 0;
    localparam int unsigned L_RX    = 1;
    localparam int unsigned L_TX    = 2;
    localparam int unsigned L_RXTO  = 3;
    localparam int unsigned L_MODEM = 4;
    localparam int unsigned L_ERR   = 5;

    localparam stat_t LINE_GRP [NUM_LINES] = '{GRP_ALL, GRP_RX, GRP_TX, GRP_RXTO, GRP_MODEM, GRP_ERR};

endpackage

// File: rtl/uart_irq_status.sv
module uart_irq_status
    import uart_irq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  stat_t set_vec,
    input  logic  clr_we,
    input  stat_t clr_vec,
    output stat_t raw_d,
    output stat_t raw_q
);

    typedef struct packed {
        stat_t raw;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        stat_t clr_eff;
        st_d    = st_q;
        clr_eff = clr_we ? clr_vec : '0;
        // set strobes are ORed after the clear so a coincident set wins
        st_d.raw = (st_q.raw & ~clr_eff) | set_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign raw_d = st_d.raw;
    assign raw_q = st_q.raw;

    p_set_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((raw_q & $past(set_vec)) == $past(set_vec)));

    p_set_beats_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && ((set_vec & clr_vec) != '0)) |=>
            ((raw_q & $past(set_vec & clr_vec)) == $past(set_vec & clr_vec)));

    p_w1c_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((raw_q & $past(clr_vec & ~set_vec)) == '0));

    p_untouched_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((raw_q ^ $past(raw_q)) & ~$past(set_vec)
                   & ~($past(clr_we) ? $past(clr_vec) : '0)) == '0));

endmodule

// File: rtl/uart_irq_enable.sv
module uart_irq_enable
    import uart_irq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_en,
    input  stat_t wr_data,
    output stat_t en_d,
    output stat_t en_q
);

    typedef struct packed {
        stat_t en;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) st_d.en = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_d = st_d.en;
    assign en_q = st_q.en;

    p_enable_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (en_q == $past(wr_data)));

    p_enable_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(en_q));

endmodule

// File: rtl/uart_irq_route.sv
module uart_irq_route
    import uart_irq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  stat_t                masked_next,
    output logic [NUM_LINES-1:0] lines_q
);

    typedef struct packed {
        logic [NUM_LINES-1:0] lines;
    } st_t;

    st_t st_d, st_q;
    logic [NUM_LINES-1:0] grp_hit;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        assign grp_hit[g] = |(masked_next & LINE_GRP[g]);
    end

    always_comb begin
        st_d       = st_q;
        st_d.lines = grp_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lines_q = st_q.lines;

    p_summary_covers_groups_r9: assert property (@(posedge clk) disable iff (!rst_n)
        lines_q[L_ANY] == (|lines_q[NUM_LINES-1:1]));

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
    import uart_irq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ev_rx,
    input  logic        ev_tx,
    input  logic        ev_rxto,
    input  logic [3:0]  ev_err,
    input  logic [3:0]  ev_modem,
    input  logic        enable_we,
    input  logic [10:0] enable_wdata,
    input  logic        clear_we,
    input  logic [10:0] clear_wdata,
    output logic [10:0] raw_stat,
    output logic [10:0] masked_stat,
    output logic        irq_any,
    output logic        irq_rx,
    output logic        irq_tx,
    output logic        irq_rxto,
    output logic        irq_modem,
    output logic        irq_err
);

    stat_t                set_vec;
    stat_t                raw_d, raw_q;
    stat_t                en_d, en_q;
    logic [NUM_LINES-1:0] lines_q;

    always_comb begin
        set_vec           = '0;
        set_vec[B_OVR]    = ev_err[3];
        set_vec[B_BRK]    = ev_err[2];
        set_vec[B_PAR]    = ev_err[1];
        set_vec[B_FRM]    = ev_err[0];
        set_vec[B_RXTO]   = ev_rxto;
        set_vec[B_TX]     = ev_tx;
        set_vec[B_RX]     = ev_rx;
        set_vec[B_DSR]    = ev_modem[3];
        set_vec[B_DCD]    = ev_modem[2];
        set_vec[B_CTS]    = ev_modem[1];
        set_vec[B_RING]   = ev_modem[0];
    end

    uart_irq_status u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_we  (clear_we),
        .clr_vec (clear_wdata),
        .raw_d   (raw_d),
        .raw_q   (raw_q)
    );

    uart_irq_enable u_enable (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (enable_we),
        .wr_data (enable_wdata),
        .en_d    (en_d),
        .en_q    (en_q)
    );

    // lines are computed from next-state values so they move on the same edge
    uart_irq_route u_route (
        .clk         (clk),
        .rst_n       (rst_n),
        .masked_next (raw_d & en_d),
        .lines_q     (lines_q)
    );

    assign raw_stat    = raw_q;
    assign masked_stat = raw_q & en_q;
    assign irq_any     = lines_q[L_ANY];
    assign irq_rx      = lines_q[L_RX];
    assign irq_tx      = lines_q[L_TX];
    assign irq_rxto    = lines_q[L_RXTO];
    assign irq_modem   = lines_q[L_MODEM];
    assign irq_err     = lines_q[L_ERR];

    p_reset_quiet_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (raw_q == '0 && en_q == '0 && lines_q == '0));

    p_masked_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((masked_stat & ~en_q) == '0) && ((masked_stat & ~raw_q) == '0));

    p_single_lines_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_rx == masked_stat[B_RX]) && (irq_tx == masked_stat[B_TX])
        && (irq_rxto == masked_stat[B_RXTO]));

    p_group_lines_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_err == (|(masked_stat & GRP_ERR))) && (irq_modem == (|(masked_stat & GRP_MODEM))));

    p_summary_line_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_any == (|masked_stat));

    p_lines_follow_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_q == $past(raw_q) && en_q == $past(en_q)) |-> $stable(lines_q));

endmodule

// File: tb/uart_irq_ctrl_test.sv
module uart_irq_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_rx = 0, ev_tx = 0, ev_rxto = 0;
    logic [3:0]  ev_err = '0, ev_modem = '0;
    logic        enable_we = 0, clear_we = 0;
    logic [10:0] enable_wdata = '0, clear_wdata = '0;
    logic [10:0] raw_stat, masked_stat;
    logic        irq_any, irq_rx, irq_tx, irq_rxto, irq_modem, irq_err;

    int checks = 0;
    int errors = 0;
    logic [10:0] cur_en = '0;

    always #2 clk = ~clk;   // 250 MHz

    uart_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n),
        .ev_rx(ev_rx), .ev_tx(ev_tx), .ev_rxto(ev_rxto),
        .ev_err(ev_err), .ev_modem(ev_modem),
        .enable_we(enable_we), .enable_wdata(enable_wdata),
        .clear_we(clear_we), .clear_wdata(clear_wdata),
        .raw_stat(raw_stat), .masked_stat(masked_stat),
        .irq_any(irq_any), .irq_rx(irq_rx), .irq_tx(irq_tx),
        .irq_rxto(irq_rxto), .irq_modem(irq_modem), .irq_err(irq_err)
    );

    // {set, en_we, en_data, clr_we, clr_data, exp_raw, exp_lines{any,err,modem,rxto,tx,rx}}
    localparam int NV = 13;
    localparam logic [51:0] VEC [NV] = '{
        {11'h010, 1'b0, 11'h000, 1'b0, 11'h000, 11'h010, 6'b000000},
        {11'h000, 1'b1, 11'h7FF, 1'b0, 11'h000, 11'h010, 6'b100001},
        {11'h020, 1'b0, 11'h000, 1'b1, 11'h010, 11'h020, 6'b100010},
        {11'h401, 1'b0, 11'h000, 1'b0, 11'h000, 11'h421, 6'b111010},
        {11'h000, 1'b1, 11'h040, 1'b0, 11'h000, 11'h421, 6'b000000},
        {11'h040, 1'b0, 11'h000, 1'b0, 11'h000, 11'h461, 6'b100100},
        {11'h040, 1'b0, 11'h000, 1'b1, 11'h040, 11'h461, 6'b100100},
        {11'h000, 1'b1, 11'h780, 1'b1, 11'h7FF, 11'h000, 6'b000000},
        {11'h080, 1'b0, 11'h000, 1'b0, 11'h000, 11'h080, 6'b110000},
        {11'h008, 1'b1, 11'h00F, 1'b0, 11'h000, 11'h088, 6'b101000},
        {11'h000, 1'b0, 11'h000, 1'b1, 11'h000, 11'h088, 6'b101000},
        {11'h000, 1'b0, 11'h000, 1'b1, 11'h080, 11'h008, 6'b101000},
        {11'h000, 1'b0, 11'h000, 1'b1, 11'h008, 11'h000, 6'b000000}
    };

    function automatic logic [5:0] lines_now();
        return {irq_any, irq_err, irq_modem, irq_rxto, irq_tx, irq_rx};
    endfunction

    task automatic chk(input string req, input logic [10:0] act, input logic [10:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive_set(input logic [10:0] s);
        ev_err   = s[10:7];
        ev_rxto  = s[6];
        ev_tx    = s[5];
        ev_rx    = s[4];
        ev_modem = s[3:0];
    endtask

    task automatic idle_inputs();
        drive_set('0);
        enable_we = 0; enable_wdata = '0;
        clear_we = 0;  clear_wdata = '0;
    endtask

    // drive at a falling edge, one rising edge, then sample at the next falling edge
    task automatic step(input logic [10:0] s, input logic ew, input logic [10:0] ed,
                        input logic cw, input logic [10:0] cd);
        @(negedge clk);
        drive_set(s);
        enable_we = ew; enable_wdata = ed;
        clear_we = cw;  clear_wdata = cd;
        if (ew) cur_en = ed;
        @(negedge clk);
        idle_inputs();
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [51:0] v;
        logic [10:0] prev_raw;
        repeat (3) @(negedge clk);
        // R1 during reset
        chk("R1 raw in reset", raw_stat, '0);
        chk("R1 lines in reset", 11'(lines_now()), '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 raw after reset", raw_stat, '0);
        chk("R1 masked after reset", masked_stat, '0);

        // vector table: R2 R3 R4 R5 R6 R7 R8 R9
        for (int i = 0; i < NV; i++) begin
            v = VEC[i];
            step(v[51:41], v[40], v[39:29], v[28], v[27:17]);
            chk($sformatf("R2/R5/R6 raw vec %0d", i), raw_stat, v[16:6]);
            chk($sformatf("R3 masked vec %0d", i), masked_stat, v[16:6] & cur_en);
            chk($sformatf("R7/R8/R9 lines vec %0d", i), 11'(lines_now()), 11'(v[5:0]));
        end

        // R2 walk of every strobe position with all enables on
        step('0, 1'b1, 11'h7FF, 1'b0, '0);
        for (int b = 0; b < 11; b++) begin
            step(11'(1 << b), 1'b0, '0, 1'b0, '0);
            chk($sformatf("R2 bit %0d raw", b), raw_stat, 11'(1 << b));
            chk($sformatf("R9 any bit %0d", b), 11'(irq_any), 11'd1);
            chk($sformatf("R8 err bit %0d", b), 11'(irq_err), 11'(b >= 7));
            chk($sformatf("R8 modem bit %0d", b), 11'(irq_modem), 11'(b <= 3));
            step('0, 1'b0, '0, 1'b1, 11'h7FF);
            chk($sformatf("R5 clear bit %0d", b), raw_stat, '0);
        end

        // R10 timing: nothing changes before the rising edge
        @(negedge clk);
        ev_tx = 1'b1;
        #1;
        chk("R10 raw before edge", raw_stat, '0);
        chk("R10 tx line before edge", 11'(irq_tx), '0);
        @(negedge clk);
        ev_tx = 1'b0;
        chk("R10 raw after edge", raw_stat, 11'h020);
        chk("R10 tx line after edge", 11'(irq_tx), 11'd1);
        // R4/R10 masking off drops the line at one edge
        @(negedge clk);
        enable_we = 1'b1; enable_wdata = 11'h000; cur_en = '0;
        #1;
        chk("R10 line held before enable edge", 11'(irq_tx), 11'd1);
        @(negedge clk);
        enable_we = 1'b0;
        chk("R4 line off after enable write", 11'(irq_tx), '0);
        chk("R4 raw kept after enable write", raw_stat, 11'h020);
        chk("R3 masked zero", masked_stat, '0);

        // R1 mid-run reset clears status and enables
        step(11'h7FF, 1'b1, 11'h7FF, 1'b0, '0);
        prev_raw = raw_stat;
        chk("R2 all set", prev_raw, 11'h7FF);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R1 raw in mid reset", raw_stat, '0);
        chk("R1 lines in mid reset", 11'(lines_now()), '0);
        @(negedge clk);
        rst_n = 1'b1;
        cur_en = '0;
        step(11'h010, 1'b0, '0, 1'b0, '0);
        chk("R1 enable zero after reset", masked_stat, '0);
        chk("R1 no line after reset", 11'(irq_rx), '0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule